// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous request source and an asynchronous static RAM that has two chip enables of opposite polarity, an active-low write enable and an active-low output enable. A requester raises `req` with an address and a data word. The sequencer latches them, asserts both chip enables, and then lowers write enable. It turns its own data-bus driver on only after the memory has had time to float its outputs. It raises write enable to close the write, and pulses `ack` on that edge.

Every analog minimum is a parameter counted in clock cycles, rounded up from nanoseconds by the integrator. The block derives three phase lengths from them:
- the chip-enable lead before write enable falls,
- the write-enable low phase,
- the chip-enable tail after write enable rises.

Output enable is never asserted, because the block only writes. A new write is not started until the write-cycle count has run out since the previous start.

Top module: `sram_write_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, the outputs are `sram_ce1_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_dq_oe`=0 and `ack`=0. Address and data outputs reset to zero.
- R2: `sram_we_n` is low only while `sram_ce1_n` is low and `sram_ce2` is high. The chip enables become active LEAD cycles before write enable falls, where LEAD = max(1, T_SCE_CYC-WLOW, T_AW_CYC-WLOW). They stay active for TAIL = max(1, T_TAIL_CYC) cycles after write enable rises.
- R3: Write enable stays low for exactly WLOW = max(T_PWE_CYC, max(T_SD_CYC,1)+T_HZ_CYC) cycles.
- R4: `sram_dq_oe` rises T_HZ_CYC cycles after write enable falls. It falls on the same clock edge on which write enable rises, so it is high for WLOW-T_HZ_CYC cycles, and that is at least T_SD_CYC.
- R5: `ack` is high for exactly one cycle, starting on the clock edge where `sram_we_n` rises, and at no other time.
- R6: `addr` and `wdata` are captured on the edge that starts a write. `sram_addr` and `sram_dq_out` hold those values for as long as the chip enables are active. A memory written at the rising edge of write enable therefore holds the requested word.
- R7: A write starts on an edge where `req` is high, the previous write has finished, and at least T_WC_CYC edges have passed since the previous start. The earliest start is the edge after the chip enables drop.
- R8: `sram_oe_n` is high at all times.
- R9: From chip-enable assertion, and from address change, to the rise of write enable there are LEAD+WLOW cycles. This is at least T_SCE_CYC and at least T_AW_CYC.
- R10: `req` low on an idle edge starts nothing. Changes on `addr` and `wdata` after a write starts have no effect on that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Write request, level sensitive |
| addr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle pulse as the write closes |
| sram_addr | output | ADDR_W | Address to the memory |
| sram_dq_out | output | DATA_W | Data to the bidirectional bus driver |
| sram_dq_oe | output | 1 | Enable of the data-bus driver |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable, held inactive |

## Verification
Three events share one clock edge: the rise of write enable, the release of the bus driver, and the acknowledge pulse. The memory model also writes on that same edge, so a driver released one cycle early or one cycle late would corrupt the stored word or collide with the memory. Every write provokes this edge. A behavioural model compares all three strobes on every clock, and a read-back of the modelled memory after the run confirms the stored words. Holding `req` high while `addr` and `wdata` change every cycle makes the write-cycle gate, not the end of the sequence, decide each start.

// File: rtl/sram_wseq_pkg.sv
// Package: shared state type and helper for the SRAM write sequencer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package sram_wseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_WLOW = 2'd2,
        ST_TAIL = 2'd3
    } wseq_state_e;

    // larger of two integers, usable in localparams
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wseq_gap.sv
// Module: write-cycle gate.
// Counts down from the write-cycle minimum on every start. Reports ready when
// another start may happen on the next edge.
// Assumes: start is a single-cycle qualifier sampled on the rising edge.
module sram_wseq_gap #(
    parameter int T_WC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int GAP_W = $clog2(sram_wseq_pkg::imax(T_WC_CYC, 1) + 1);

    generate
        if (T_WC_CYC <= 1) begin : g_free
            // no spacing needed beyond the sequence itself
            assign ready = 1'b1;
        end else begin : g_count
            logic [GAP_W-1:0] remain;

            // reload on start, then run down to zero
            always_ff @(posedge clk) begin
                if (!rst_n)             remain <= '0;
                else if (start)         remain <= GAP_W'(T_WC_CYC - 1);
                else if (remain != '0)  remain <= remain - 1'b1;
            end

            assign ready = (remain == '0);
        end
    endgenerate

endmodule

// File: rtl/sram_wseq_fsm.sv
// Module: strobe sequencer.
// Walks the lead, write-low and tail phases with one down counter. All strobes
// are registered from the next state, so the pins never carry decode glitches.
// Assumes: LEAD, WLOW and TAIL are at least 1, and HZ is below WLOW.
module sram_wseq_fsm
    import sram_wseq_pkg::*;
#(
    parameter int LEAD = 1,
    parameter int WLOW = 4,
    parameter int HZ   = 2,
    parameter int TAIL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic accept,
    output logic ce_q,
    output logic we_q,
    output logic drv_q,
    output logic done_q
);
    localparam int CNT_W    = $clog2(imax(imax(LEAD, WLOW), TAIL) + 1);
    localparam int DRV_LAST = WLOW - 1 - HZ;

    wseq_state_e      st, nxt_st;
    logic [CNT_W-1:0] cnt, nxt_cnt;

    // next phase and phase counter
    always_comb begin
        nxt_st  = st;
        nxt_cnt = cnt;
        accept  = 1'b0;
        case (st)
            ST_IDLE: if (go) begin
                accept  = 1'b1;
                nxt_st  = ST_LEAD;
                nxt_cnt = CNT_W'(LEAD - 1);
            end
            ST_LEAD: if (cnt == '0) begin
                nxt_st  = ST_WLOW;
                nxt_cnt = CNT_W'(WLOW - 1);
            end else nxt_cnt = cnt - 1'b1;
            ST_WLOW: if (cnt == '0) begin
                nxt_st  = ST_TAIL;
                nxt_cnt = CNT_W'(TAIL - 1);
            end else nxt_cnt = cnt - 1'b1;
            ST_TAIL: if (cnt == '0) begin
                nxt_st  = ST_IDLE;
                nxt_cnt = '0;
            end else nxt_cnt = cnt - 1'b1;
            default: begin
                nxt_st  = ST_IDLE;
                nxt_cnt = '0;
            end
        endcase
    end

    // phase registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt_st;
            cnt <= nxt_cnt;
        end
    end

    // registered strobes, active high inside the block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b0;
            we_q   <= 1'b0;
            drv_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            ce_q   <= (nxt_st != ST_IDLE);
            we_q   <= (nxt_st == ST_WLOW);
            drv_q  <= (nxt_st == ST_WLOW) && (nxt_cnt <= CNT_W'(DRV_LAST));
            done_q <= (st == ST_WLOW) && (cnt == '0);
        end
    end

    p_we_inside_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> ce_q);
    p_ce_before_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_q) |-> $past(ce_q));
    p_ce_after_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_q) |-> ce_q);
    p_drv_inside_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q |-> we_q);
    p_ack_at_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $fell(we_q));
    p_close_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_q) |-> done_q);
    p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/sram_wseq_datapath.sv
// Module: address and data holding registers.
// Captures the request on the start edge and holds it for the whole write.
// Assumes: load is high for one cycle per write.
module sram_wseq_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out
);
    // capture request fields on start only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
            data_out <= '0;
        end else if (load) begin
            addr_out <= addr_in;
            data_out <= data_in;
        end
    end
endmodule

// File: rtl/sram_write_seq.sv
// Module: top of the asynchronous SRAM write sequencer.
// Turns req/ack writes into chip-enable, write-enable and driver-enable
// waveforms. Each write is closed by the rising edge of write enable.
// Assumes: the T_* parameters are nanosecond minimums already rounded up to
// whole clock cycles, and the data bus is driven by an external tristate pad.
module sram_write_seq
    import sram_wseq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int T_WC_CYC   = 4,
    parameter int T_SCE_CYC  = 3,
    parameter int T_AW_CYC   = 3,
    parameter int T_PWE_CYC  = 2,
    parameter int T_SD_CYC   = 2,
    parameter int T_HZ_CYC   = 2,
    parameter int T_TAIL_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    localparam int SD_EFF = imax(T_SD_CYC, 1);
    localparam int WLOW   = imax(T_PWE_CYC, SD_EFF + T_HZ_CYC);
    localparam int LEAD   = imax(1, imax(T_SCE_CYC - WLOW, T_AW_CYC - WLOW));
    localparam int TAIL   = imax(1, T_TAIL_CYC);

    logic gap_ready, accept, ce_act, we_act, drv_act, done;

    sram_wseq_gap #(.T_WC_CYC(T_WC_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .start(accept), .ready(gap_ready)
    );

    sram_wseq_fsm #(.LEAD(LEAD), .WLOW(WLOW), .HZ(T_HZ_CYC), .TAIL(TAIL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(req && gap_ready), .accept(accept),
        .ce_q(ce_act), .we_q(we_act), .drv_q(drv_act), .done_q(done)
    );

    sram_wseq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .addr_in(addr), .data_in(wdata),
        .addr_out(sram_addr), .data_out(sram_dq_out)
    );

    // pin polarities
    assign sram_ce1_n = ~ce_act;
    assign sram_ce2   = ce_act;
    assign sram_we_n  = ~we_act;
    assign sram_dq_oe = drv_act;
    assign sram_oe_n  = 1'b1;
    assign ack        = done;

    // run-length counters feeding the timing assertions only
    int we_run, drv_run, ce_run, gap_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run  <= 0;
            drv_run <= 0;
            ce_run  <= 0;
            gap_run <= T_WC_CYC;
        end else begin
            we_run  <= we_act  ? we_run + 1  : 0;
            drv_run <= drv_act ? drv_run + 1 : 0;
            ce_run  <= ce_act  ? ce_run + 1  : 0;
            if (accept)                gap_run <= 1;
            else if (gap_run < T_WC_CYC) gap_run <= gap_run + 1;
        end
    end

    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_run == WLOW) && (we_run >= T_PWE_CYC));
    p_drv_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (drv_run == WLOW - T_HZ_CYC) && (drv_run >= T_SD_CYC));
    p_ce_to_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (ce_run >= T_SCE_CYC) && (ce_run >= T_AW_CYC));
    p_cycle_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> gap_run >= T_WC_CYC);
    p_bus_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_act && $past(ce_act)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

endmodule

// File: tb/tb_sram_write_seq.sv
// Bench: behavioural phase model compared on every falling edge, plus a
// memory written on the closing edge of each write and per-write timing checks.
module tb_sram_write_seq;
    localparam int AW = 16, DW = 8;
    localparam int WC = 9, SCE = 3, AWC = 3, PWE = 2, SD = 2, HZ = 2, TL = 1;
    localparam int WL   = (PWE > SD + HZ) ? PWE : SD + HZ;
    localparam int LD0  = (SCE - WL > AWC - WL) ? SCE - WL : AWC - WL;
    localparam int LEAD = (LD0 > 1) ? LD0 : 1;
    localparam int SEQ  = LEAD + WL + TL;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic ack, dq_oe, ce1_n, ce2, we_n, oe_n;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_dq;

    always #2 clk = ~clk;

    sram_write_seq #(.ADDR_W(AW), .DATA_W(DW), .T_WC_CYC(WC), .T_SCE_CYC(SCE),
        .T_AW_CYC(AWC), .T_PWE_CYC(PWE), .T_SD_CYC(SD), .T_HZ_CYC(HZ),
        .T_TAIL_CYC(TL)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata),
        .ack(ack), .sram_addr(s_addr), .sram_dq_out(s_dq), .sram_dq_oe(dq_oe),
        .sram_ce1_n(ce1_n), .sram_ce2(ce2), .sram_we_n(we_n), .sram_oe_n(oe_n));

    int checks = 0, fails = 0, cycles = 0;
    int ph = -1, since = WC;
    bit started = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    logic [DW-1:0] exp_mem [int];
    logic [DW-1:0] mem [int];

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, expv, cycles);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // reference phase model: one step per rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            ph = -1; since = WC;
        end else begin
            since++;
            if (ph >= 0) begin
                ph++;
                if (ph == SEQ) ph = -1;
            end else if (req && since >= WC) begin
                ph = 0; since = 0;
                m_addr = addr; m_data = wdata;
                exp_mem[int'(addr)] = wdata;
            end
        end
    end

    // compare, memory model and timing measurements on the falling edge
    int we_len = 0, drv_len = 0, ce_len = 0;
    logic p_we = 1'b1, p_oe = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq = '0;
    always @(negedge clk) begin
        bit e_ce, e_we, e_drv, e_ack;
        cycles++;
        if (cycles > 20000) begin
            chk(0, "watchdog", cycles, 20000);
            finish_run();
        end
        if (started) begin
            e_ce  = (ph >= 0);
            e_we  = (ph >= LEAD) && (ph < LEAD + WL);
            e_drv = (ph >= LEAD + HZ) && (ph < LEAD + WL);
            e_ack = (ph == LEAD + WL);
            if (!rst_n)
                chk(ce1_n && !ce2 && we_n && !dq_oe && !ack && s_addr == 0 && s_dq == 0,
                    "R1 reset state", {ce1_n, ce2, we_n, dq_oe, ack}, 5'b10100);
            chk(ce1_n == !e_ce && ce2 == e_ce, "R2/R7 chip enables", {ce1_n, ce2}, {!e_ce, e_ce});
            chk(we_n == !e_we, "R3 write enable", we_n, !e_we);
            chk(dq_oe == e_drv, "R4 driver enable", dq_oe, e_drv);
            chk(ack == e_ack, "R5 ack", ack, e_ack);
            chk(oe_n == 1'b1, "R8 output enable", oe_n, 1);
            if (e_ce) begin
                chk(s_addr == m_addr, "R6/R10 address", s_addr, m_addr);
                chk(s_dq == m_data, "R6/R10 data", s_dq, m_data);
            end
            if (!p_we && we_n) begin
                chk(we_len == WL && we_len >= PWE, "R3 low width", we_len, WL);
                chk(drv_len == WL - HZ && drv_len >= SD, "R4 setup", drv_len, WL - HZ);
                chk(ce_len >= SCE && ce_len >= AWC && ce_len == LEAD + WL, "R9 enable to end", ce_len, LEAD + WL);
                if (p_oe) mem[int'(p_addr)] = p_dq;
            end
            we_len  = !we_n ? we_len + 1 : 0;
            drv_len = dq_oe ? drv_len + 1 : 0;
            ce_len  = !ce1_n ? ce_len + 1 : 0;
            p_we = we_n; p_oe = dq_oe; p_addr = s_addr; p_dq = s_dq;
        end
    end

    task automatic write_one(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req = 1'b1; addr = a; wdata = d;
        do @(negedge clk); while (!ack);
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // single writes with varied patterns
        for (int i = 0; i < 4; i++)
            write_one(AW'(16'h1000 + i * 37), DW'(8'hA5 ^ (i * 8'h11)));
        // idle with req low: nothing may start (R10)
        repeat (20) @(negedge clk);
        // req held, inputs change every cycle: gate decides starts (R7, R10)
        req = 1'b1;
        for (int i = 0; i < 60; i++) begin
            addr  = AW'(16'h2000 + i * 3);
            wdata = DW'(i * 7 + 1);
            @(negedge clk);
        end
        req = 1'b0;
        repeat (12) @(negedge clk);
        // address and data extremes
        write_one('0, '0);
        write_one('1, '1);
        repeat (12) @(negedge clk);
        // read back the modelled memory (R6)
        foreach (exp_mem[k])
            chk(mem.exists(k) && mem[k] == exp_mem[k], "R6 stored word",
                mem.exists(k) ? mem[k] : -1, exp_mem[k]);
        finish_run();
    end
endmodule